// File: doc/BRIEF.md
# Zero-Axis Hysteresis Zero-Vector Selector

This block sits beside a clamped space-vector modulator in one of several power-converter modules that share a DC bus and an AC source. When the modules switch with interleaved clocks, their zero vectors can overlap. This drives a common-mode current around the loop between modules, and that current cannot be seen on the rotating two-axis controller channels. The block adds the three sampled phase currents to form the zero-axis current. It compares this sum against a signed window, and from the result picks which of the two zero vectors the modulator should apply from then on.

The modulator pulses `smp_stb` once per switching period, before the zero segment of that period starts. On that edge the block registers four things: the sum, the above and below flags, the configuration-error flag and the new zero-vector choice. It also advances a saturating use counter for the vector now selected, so that any long-term bias toward the upper or the lower switch set can be read out. Between strobes every output holds.

Top module: `zaxis_zv_selector`

## Requirements
- R1: On each strobe edge, `zsum_q` takes the exact signed sum of `ia`, `ib` and `ic`, computed at CUR_W+2 bits. For three 16-bit inputs the sum spans -98304 to 98301 without overflow.
- R2: On a strobe where the sum is strictly greater than `lim_hi`, and the limits are valid, `zv_bot` becomes 1 after that edge. The value 1 means all lower switches on.
- R3: On a strobe where the sum is strictly less than `lim_lo`, and the limits are valid, `zv_bot` becomes 0 after that edge. The value 0 means all upper switches on.
- R4: On a strobe where `lim_lo <= sum <= lim_hi`, `zv_bot` keeps its previous value. Both limits belong to the window.
- R5: With `smp_stb` low, all outputs hold their values, whatever the currents and limits do.
- R6: On a strobe where `lim_lo > lim_hi`, `cfg_err` becomes 1, `zv_bot` is held, and both `above` and `below` become 0. A later strobe with valid limits clears `cfg_err`.
- R7: On each strobe with valid limits, `above` is set to (sum > `lim_hi`) and `below` is set to (sum < `lim_lo`). The two are never 1 together.
- R8: On each strobe, the counter of the vector selected after that edge (`cnt_bot` when `zv_bot` is 1, otherwise `cnt_top`) increases by one. It saturates at 2^CNT_W-1. The other counter holds.
- R9: While reset is asserted, `zv_bot` is 0 (upper vector), `above`, `below` and `cfg_err` are 0, `zsum_q` is 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe per switching period, before the zero segment |
| ia | input | CUR_W | Signed sampled current, phase A |
| ib | input | CUR_W | Signed sampled current, phase B |
| ic | input | CUR_W | Signed sampled current, phase C |
| lim_hi | input | CUR_W+2 | Signed upper window limit |
| lim_lo | input | CUR_W+2 | Signed lower window limit |
| zv_bot | output | 1 | Selected zero vector: 1 = all lower on, 0 = all upper on |
| above | output | 1 | Last sum exceeded the upper limit |
| below | output | 1 | Last sum fell under the lower limit |
| cfg_err | output | 1 | Last strobe saw the lower limit greater than the upper |
| zsum_q | output | CUR_W+2 | Registered zero-axis current |
| cnt_top | output | CNT_W | Saturating count of strobes selecting the upper vector |
| cnt_bot | output | CNT_W | Saturating count of strobes selecting the lower vector |

## Verification
The sum is swept as a slow upward ramp and then a coarser downward ramp through a window of plus and minus 100. The two ramps split the current among the phases in different ways, so hysteresis (a hold that depends on direction) can be told apart from a plain threshold. Points on and one step past each limit separate strict from inclusive comparison. All-maximum and all-minimum inputs reveal a sum that is too narrow. Idle cycles with extreme currents, an inverted window, and a long run of one-sided strobes separate update-on-strobe, held-on-error and counter saturation from their faulty variants.

// File: rtl/zsel_pkg.sv
package zsel_pkg;
  // Zero-vector choice: encoding is visible on the zv_bot port.
  typedef enum logic {
    ZV_TOP = 1'b0,
    ZV_BOT = 1'b1
  } zv_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic bad;
  } cmp_t;
endpackage

// File: rtl/zaxis_sum.sv
module zaxis_sum #(
  parameter int CUR_W = 16,
  localparam int SUM_W = CUR_W + 2
) (
  input  logic signed [CUR_W-1:0] pa,
  input  logic signed [CUR_W-1:0] pb,
  input  logic signed [CUR_W-1:0] pc,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [SUM_W-1:0] xa, xb, xc;

  always_comb begin
    xa  = SUM_W'(pa);
    xb  = SUM_W'(pb);
    xc  = SUM_W'(pc);
    sum = xa + xb + xc;
  end
endmodule

// File: rtl/zaxis_window.sv
module zaxis_window
  import zsel_pkg::*;
#(
  parameter int SUM_W = 18
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic signed [SUM_W-1:0] hi,
  input  logic signed [SUM_W-1:0] lo,
  output cmp_t                    res
);
  always_comb begin
    res.bad = (lo > hi);
    res.gt  = !res.bad && (sum > hi);
    res.lt  = !res.bad && (sum < lo);
  end
endmodule

// File: rtl/zv_use_cnt.sv
module zv_use_cnt #(
  parameter int CNT_W = 16,
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt != CMAX);
    cnt_d  = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/zaxis_zv_selector.sv
module zaxis_zv_selector
  import zsel_pkg::*;
#(
  parameter int CUR_W = 16,
  parameter int CNT_W = 16,
  localparam int SUM_W = CUR_W + 2,
  localparam int NVEC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic signed [CUR_W-1:0] ia,
  input  logic signed [CUR_W-1:0] ib,
  input  logic signed [CUR_W-1:0] ic,
  input  logic signed [SUM_W-1:0] lim_hi,
  input  logic signed [SUM_W-1:0] lim_lo,
  output logic                    zv_bot,
  output logic                    above,
  output logic                    below,
  output logic                    cfg_err,
  output logic signed [SUM_W-1:0] zsum_q,
  output logic [CNT_W-1:0]        cnt_top,
  output logic [CNT_W-1:0]        cnt_bot
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic signed [SUM_W-1:0] zsum;
  cmp_t                    cmp;
  zv_e                     sel_q, sel_d;
  logic                    above_d, below_d, err_d;
  logic [CNT_W-1:0]        cnt_v [NVEC];

  zaxis_sum #(.CUR_W(CUR_W)) u_sum (
    .pa(ia), .pb(ib), .pc(ic), .sum(zsum)
  );

  zaxis_window #(.SUM_W(SUM_W)) u_win (
    .sum(zsum), .hi(lim_hi), .lo(lim_lo), .res(cmp)
  );

  // next state
  always_comb begin
    sel_d   = sel_q;
    above_d = cmp.gt;
    below_d = cmp.lt;
    err_d   = cmp.bad;
    if (cmp.gt)      sel_d = ZV_BOT;
    else if (cmp.lt) sel_d = ZV_TOP;
  end

  // state registers, enabled by the per-period strobe
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q   <= ZV_TOP;
      above   <= 1'b0;
      below   <= 1'b0;
      cfg_err <= 1'b0;
      zsum_q  <= '0;
    end else if (smp_stb) begin
      sel_q   <= sel_d;
      above   <= above_d;
      below   <= below_d;
      cfg_err <= err_d;
      zsum_q  <= zsum;
    end
  end

  for (genvar g = 0; g < NVEC; g++) begin : g_cnt
    zv_use_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_q),
      .inc  (smp_stb && (sel_d == zv_e'(g))),
      .cnt  (cnt_v[g])
    );
  end

  assign zv_bot  = (sel_q == ZV_BOT);
  assign cnt_top = cnt_v[0];
  assign cnt_bot = cnt_v[1];
endmodule

// File: rtl/zaxis_zv_selector_chk.sv
module zaxis_zv_selector_chk #(
  parameter int CUR_W = 16,
  parameter int CNT_W = 16,
  localparam int SUM_W = CUR_W + 2
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic                    smp_stb,
  input logic signed [CUR_W-1:0] ia,
  input logic signed [CUR_W-1:0] ib,
  input logic signed [CUR_W-1:0] ic,
  input logic signed [SUM_W-1:0] lim_hi,
  input logic signed [SUM_W-1:0] lim_lo,
  input logic                    zv_bot,
  input logic                    above,
  input logic                    below,
  input logic                    cfg_err,
  input logic signed [SUM_W-1:0] zsum_q,
  input logic [CNT_W-1:0]        cnt_top,
  input logic [CNT_W-1:0]        cnt_bot
);
  logic signed [SUM_W-1:0] ref_sum;
  logic [CNT_W:0]          tot;
  logic                    ok_lim, cnt_room;

  always_comb begin
    ref_sum  = SUM_W'(ia) + SUM_W'(ib) + SUM_W'(ic);
    ok_lim   = (lim_lo <= lim_hi);
    tot      = {1'b0, cnt_top} + {1'b0, cnt_bot};
    cnt_room = (cnt_top != {CNT_W{1'b1}}) && (cnt_bot != {CNT_W{1'b1}});
  end

  // R1
  sum_capture_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb |=> zsum_q == $past(ref_sum));
  // R2
  sel_bot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb && ok_lim && (ref_sum > lim_hi) |=> zv_bot);
  // R3
  sel_top_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb && ok_lim && (ref_sum < lim_lo) |=> !zv_bot);
  // R4
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb && (ref_sum >= lim_lo) && (ref_sum <= lim_hi) |=> $stable(zv_bot));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !smp_stb |=> $stable(zv_bot) && $stable(zsum_q) && $stable(cnt_top) && $stable(cnt_bot));
  // R6
  bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb && !ok_lim |=> cfg_err && $stable(zv_bot) && !above && !below);
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $countones({above, below}) <= 1);
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_stb && cnt_room |=> tot == $past(tot) + 1'b1);
endmodule

bind zaxis_zv_selector zaxis_zv_selector_chk #(.CUR_W(CUR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .smp_stb(smp_stb), .ia(ia), .ib(ib), .ic(ic),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .zv_bot(zv_bot), .above(above),
  .below(below), .cfg_err(cfg_err), .zsum_q(zsum_q),
  .cnt_top(cnt_top), .cnt_bot(cnt_bot)
);

// File: tb/test_zaxis_zv_selector.sv
module test_zaxis_zv_selector;
  localparam int CLK_PER = 10;
  localparam int CUR_W = 16;
  localparam int CNT_W = 8;
  localparam int SUM_W = CUR_W + 2;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, smp_stb;
  logic signed [CUR_W-1:0] ia, ib, ic;
  logic signed [SUM_W-1:0] lim_hi, lim_lo, zsum_q;
  logic zv_bot, above, below, cfg_err;
  logic [CNT_W-1:0] cnt_top, cnt_bot;

  int n_chk = 0, n_bad = 0;
  int m_sel = 0, m_ab = 0, m_bl = 0, m_err = 0, m_sum = 0, m_ct = 0, m_cb = 0;
  int hi_v = 100, lo_v = -100;
  bit done = 0;

  always #(CLK_PER / 2) clk = ~clk;

  zaxis_zv_selector #(.CUR_W(CUR_W), .CNT_W(CNT_W)) i_zaxis_zv_selector (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ia(ia), .ib(ib), .ic(ic),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .zv_bot(zv_bot), .above(above),
    .below(below), .cfg_err(cfg_err), .zsum_q(zsum_q),
    .cnt_top(cnt_top), .cnt_bot(cnt_bot)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "zv_bot", int'(zv_bot), m_sel);
    check(tag, "above", int'(above), m_ab);
    check(tag, "below", int'(below), m_bl);
    check(tag, "cfg_err", int'(cfg_err), m_err);
    check(tag, "zsum_q", int'(zsum_q), m_sum);
    check(tag, "cnt_top", int'(cnt_top), m_ct);
    check(tag, "cnt_bot", int'(cnt_bot), m_cb);
  endtask

  task automatic set_lim(int hi, int lo);
    @(negedge clk);
    hi_v = hi; lo_v = lo;
    lim_hi = SUM_W'(hi); lim_lo = SUM_W'(lo);
  endtask

  // one strobe; model follows the requirements
  task automatic strobe(string tag, int a, int b, int c);
    int s;
    @(negedge clk);
    ia = CUR_W'(a); ib = CUR_W'(b); ic = CUR_W'(c);
    smp_stb = 1'b1;
    @(posedge clk);
    s = a + b + c;
    m_sum = s;
    m_err = (lo_v > hi_v) ? 1 : 0;
    m_ab = (!m_err && s > hi_v) ? 1 : 0;
    m_bl = (!m_err && s < lo_v) ? 1 : 0;
    if (m_ab) m_sel = 1;
    else if (m_bl) m_sel = 0;
    if (m_sel == 1) begin if (m_cb < CMAX) m_cb++; end
    else begin if (m_ct < CMAX) m_ct++; end
    @(negedge clk);
    smp_stb = 1'b0;
    check_all(tag);
  endtask

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0;
    ia = '0; ib = '0; ic = '0;
    lim_hi = SUM_W'(100); lim_lo = SUM_W'(-100);
    repeat (3) @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R7: fine upward ramp, even split
    for (int s = -300; s <= 300; s += 7) strobe("R4", s / 3, s / 3, s - 2 * (s / 3));
    // coarse downward ramp, lopsided split
    for (int s = 300; s >= -300; s -= 11) strobe("R4", s + 1000, -1000, 0);

    // boundaries: inclusive window, strict outside
    strobe("R2", 101, 0, 0);
    strobe("R4", 100, 0, 0);
    strobe("R4", -100, 0, 0);
    strobe("R3", 0, -101, 0);
    strobe("R4", 99, 0, 0);
    strobe("R4", 0, 0, 100);
    strobe("R2", 0, 0, 101);

    // R1: extremes need the wide sum
    strobe("R1", 32767, 32767, 32767);
    strobe("R1", -32768, -32768, -32768);
    strobe("R1", 32767, -32768, 32767);

    // R5: idle cycles with extreme currents and limits change nothing
    @(negedge clk);
    ia = 16'sh7fff; ib = 16'sh7fff; ic = 16'sh7fff;
    lim_hi = SUM_W'(-5000); lim_lo = SUM_W'(5000);
    repeat (4) @(negedge clk);
    check_all("R5");
    set_lim(100, -100);

    // R6: inverted window holds the selection
    strobe("R2", 200, 0, 0);
    set_lim(-50, 50);
    strobe("R6", -900, 0, 0);
    strobe("R6", 900, 0, 0);
    strobe("R6", 0, 0, 0);
    set_lim(100, -100);
    strobe("R3", -900, 0, 0);
    set_lim(-50, 50);
    strobe("R6", 900, 0, 0);
    set_lim(100, -100);
    strobe("R4", 0, 0, 0);

    // R8: long one-sided run saturates the lower-vector counter
    for (int k = 0; k < CMAX + 20; k++) strobe("R8", 500, 0, 0);
    strobe("R8", -500, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule